// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous host and an external byte-wide asynchronous static memory. The host presents a request level together with a write flag, an address and write data. The controller latches these values and then plays out the memory strobes: active-low chip select, write strobe and output enable. It drives the tri-state data bus during writes and captures the returned byte during reads. A one-cycle completion pulse marks the end of each transaction.

Every memory timing figure is given as a nanosecond parameter. Each one is converted into a whole number of system clock cycles, rounded up, for a parameterised clock period. A write is controlled by the write strobe: chip select falls first, then the address setup time passes, then the write strobe is pulsed. After the pulse there is a hold period and then a recovery period. A read lowers chip select and output enable together for the access time, and the byte is sampled on the final clock edge of that access.

The data driver and the memory's output stage must never be on at the same time. The controller therefore keeps output enable high for the whole of a write. It turns its own driver on only once output enable has been high for at least the bus-release time.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is asserted and right after it, mem_ce_n, mem_we_n and mem_oe_n are 1, host_done is 0, and the controller does not drive mem_dq.
- R2: A write holds mem_ce_n low with mem_we_n high for at least the address setup count before mem_we_n falls. mem_we_n then stays low for exactly the pulse count, which is the larger of the pulse and data setup figures (3 cycles at the defaults: 20 ns clock, 55 ns pulse, 30 ns data setup).
- R3: mem_oe_n is 1 in every cycle in which mem_we_n is 0.
- R4: mem_addr does not change in any cycle in which mem_ce_n stays low, and it stays on the latched address through the hold period after the write strobe rises.
- R5: The controller drives the latched write byte on mem_dq for the whole time mem_we_n is low, so a later read of that address returns the byte.
- R6: A read holds mem_ce_n and mem_oe_n low with mem_we_n high for exactly the access count (4 cycles at the defaults: 70 ns access time). On the cycle host_done is 1, host_rdata holds the byte the memory presented at the end of that access.
- R7: The data driver is enabled only after mem_oe_n has been 1 for at least the bus-release count (2 cycles for 30 ns). A write that follows a read directly still stores its byte correctly.
- R8: Each accepted request produces exactly one host_done pulse, and that pulse is one cycle long.
- R9: Between two transactions, mem_ce_n stays high for at least the recovery count plus one idle cycle (2 cycles at the defaults).
- R10: Address, data and the write flag are latched when a request is accepted. A request is accepted only while the controller is idle, so changing the host inputs after acceptance has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request level; it is taken when the controller is idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 21 | Byte address |
| host_wdata | input | 8 | Byte to write |
| host_rdata | output | 8 | Byte captured by the last read |
| host_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 21 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq | inout | 8 | Bidirectional memory data bus |

## Verification
The bench writes bytes of all ones, all zeros and mixed patterns to addresses whose upper bits differ widely. It then reads them back, which separates a correctly latched and driven write byte from a stale or undriven bus. Reads of locations that were never written show whether the sampled value really comes from the memory rather than from the last write. A read followed directly by a write to the same location, with a read after it, tests the bus-release wait. A write whose host inputs are scrambled after acceptance shows whether the request is latched or sampled live.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WSET  = 3'd1,
    ST_WPUL  = 3'd2,
    ST_WHLD  = 3'd3,
    ST_RACC  = 3'd4,
    ST_REC   = 3'd5
  } sram_state_e;

  // Nanoseconds to clock cycles, rounded up, never below one cycle.
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int C_AS  = 1,
  parameter int C_WP  = 3,
  parameter int C_HLD = 1,
  parameter int C_REC = 1,
  parameter int C_RD  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_req,
  input  logic             host_wr,
  input  logic             tmr_expired,
  input  logic             bus_free,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             accept,
  output logic             capture,
  output logic             ce_n,
  output logic             we_n,
  output logic             oe_n,
  output logic             drive_req,
  output logic             done
);

  sram_state_e state_q, state_d;
  logic ce_q, ce_d, we_q, we_d, oe_q, oe_d, drv_q, drv_d, done_q, done_d;

  always_comb begin
    state_d  = state_q;
    ce_d     = ce_q;
    we_d     = we_q;
    oe_d     = oe_q;
    drv_d    = drv_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (host_req) begin
          accept   = 1'b1;
          tmr_load = 1'b1;
          ce_d     = 1'b0;
          if (host_wr) begin
            state_d = ST_WSET;
            drv_d   = 1'b1;
            tmr_val = CNT_W'(C_AS - 1);
          end else begin
            state_d = ST_RACC;
            oe_d    = 1'b0;
            tmr_val = CNT_W'(C_RD - 1);
          end
        end
      end
      ST_WSET: begin
        if (tmr_expired && bus_free) begin
          state_d  = ST_WPUL;
          we_d     = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(C_WP - 1);
        end
      end
      ST_WPUL: begin
        if (tmr_expired) begin
          state_d  = ST_WHLD;
          we_d     = 1'b1;
          ce_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(C_HLD - 1);
        end
      end
      ST_WHLD: begin
        if (tmr_expired) begin
          state_d  = ST_REC;
          drv_d    = 1'b0;
          done_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(C_REC - 1);
        end
      end
      ST_RACC: begin
        if (tmr_expired) begin
          state_d  = ST_REC;
          capture  = 1'b1;
          ce_d     = 1'b1;
          oe_d     = 1'b1;
          done_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(C_REC - 1);
        end
      end
      ST_REC: begin
        if (tmr_expired) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        ce_d    = 1'b1;
        we_d    = 1'b1;
        oe_d    = 1'b1;
        drv_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_q    <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b1;
      drv_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_q    <= ce_d;
      we_q    <= we_d;
      oe_q    <= oe_d;
      drv_q   <= drv_d;
      done_q  <= done_d;
    end
  end

  assign ce_n      = ce_q;
  assign we_n      = we_q;
  assign oe_n      = oe_q;
  assign drive_req = drv_q;
  assign done      = done_q;

endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 8,
  parameter int C_REL  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              oe_n,
  input  logic              drive_req,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              drive_en,
  output logic              bus_free,
  output logic [DATA_W-1:0] rdata
);

  localparam int REL_W = $clog2(C_REL + 1);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [REL_W-1:0]  rel_q, rel_d;
  logic              rel_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= dq_in;
    end
  end

  // Counts cycles with output enable high, saturating at the release count.
  always_comb begin
    rel_en = !oe_n ? (rel_q != '0) : (rel_q != REL_W'(C_REL));
    rel_d  = !oe_n ? '0 : (rel_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q <= REL_W'(C_REL);
    end else if (rel_en) begin
      rel_q <= rel_d;
    end
  end

  assign bus_free = (rel_q == REL_W'(C_REL)) && oe_n;
  assign drive_en = drive_req && bus_free;
  assign addr     = addr_q;
  assign dq_out   = wdata_q;
  assign rdata    = rdata_q;

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W          = 21,
  parameter int DATA_W          = 8,
  parameter int CLK_PERIOD_NS   = 20,
  parameter int T_ADDR_SETUP_NS = 10,
  parameter int T_WE_PULSE_NS   = 55,
  parameter int T_DATA_SETUP_NS = 30,
  parameter int T_DATA_HOLD_NS  = 0,
  parameter int T_ADDR_HOLD_NS  = 5,
  parameter int T_RECOVERY_NS   = 5,
  parameter int T_READ_NS       = 70,
  parameter int T_OE_ACCESS_NS  = 35,
  parameter int T_RELEASE_NS    = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  inout  wire  [DATA_W-1:0] mem_dq
);

  localparam int C_AS  = ns_to_cyc(T_ADDR_SETUP_NS, CLK_PERIOD_NS);
  localparam int C_WP  = imax(ns_to_cyc(T_WE_PULSE_NS, CLK_PERIOD_NS),
                              ns_to_cyc(T_DATA_SETUP_NS, CLK_PERIOD_NS));
  localparam int C_HLD = imax(ns_to_cyc(T_DATA_HOLD_NS, CLK_PERIOD_NS),
                              ns_to_cyc(T_ADDR_HOLD_NS, CLK_PERIOD_NS));
  localparam int C_REC = ns_to_cyc(T_RECOVERY_NS, CLK_PERIOD_NS);
  localparam int C_RD  = imax(ns_to_cyc(T_READ_NS, CLK_PERIOD_NS),
                              ns_to_cyc(T_OE_ACCESS_NS, CLK_PERIOD_NS));
  localparam int C_REL = ns_to_cyc(T_RELEASE_NS, CLK_PERIOD_NS);
  localparam int C_MAX = imax(imax(imax(C_AS, C_WP), imax(C_HLD, C_REC)), C_RD);
  localparam int CNT_W = $clog2(C_MAX + 1);

  logic             tmr_load, tmr_expired;
  logic [CNT_W-1:0] tmr_val;
  logic             accept, capture, drive_req, dq_drive, bus_free;
  logic [DATA_W-1:0] dq_out;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  sram_seq_fsm #(
    .CNT_W (CNT_W),
    .C_AS  (C_AS),
    .C_WP  (C_WP),
    .C_HLD (C_HLD),
    .C_REC (C_REC),
    .C_RD  (C_RD)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_wr     (host_wr),
    .tmr_expired (tmr_expired),
    .bus_free    (bus_free),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .accept      (accept),
    .capture     (capture),
    .ce_n        (mem_ce_n),
    .we_n        (mem_we_n),
    .oe_n        (mem_oe_n),
    .drive_req   (drive_req),
    .done        (host_done)
  );

  sram_data_path #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .C_REL  (C_REL)
  ) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .capture   (capture),
    .oe_n      (mem_oe_n),
    .drive_req (drive_req),
    .in_addr   (host_addr),
    .in_wdata  (host_wdata),
    .dq_in     (mem_dq),
    .addr      (mem_addr),
    .dq_out    (dq_out),
    .drive_en  (dq_drive),
    .bus_free  (bus_free),
    .rdata     (host_rdata)
  );

  assign mem_dq = dq_drive ? dq_out : {DATA_W{1'bz}};

endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
  parameter int ADDR_W = 21,
  parameter int C_WP   = 3,
  parameter int C_RD   = 4,
  parameter int C_REL  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              drive_en,
  input logic              host_done
);

  logic [7:0] we_low_q, oe_low_q, oe_high_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_q  <= '0;
      oe_low_q  <= '0;
      oe_high_q <= 8'(C_REL);
    end else begin
      we_low_q  <= !mem_we_n ? we_low_q + ((we_low_q != 8'hFF) ? 8'd1 : 8'd0) : 8'd0;
      oe_low_q  <= !mem_oe_n ? oe_low_q + ((oe_low_q != 8'hFF) ? 8'd1 : 8'd0) : 8'd0;
      oe_high_q <= mem_oe_n ? oe_high_q + ((oe_high_q != 8'hFF) ? 8'd1 : 8'd0) : 8'd0;
    end
  end

  assert_we_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_q == 8'(C_WP)));

  assert_we_under_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> (!mem_ce_n && $past(!mem_ce_n)));

  assert_no_oe_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_addr_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_data_during_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> drive_en);

  assert_read_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_low_q == 8'(C_RD)));

  assert_read_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (!mem_ce_n && mem_we_n));

  assert_bus_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drive_en |-> (mem_oe_n && oe_high_q >= 8'(C_REL)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);

endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .C_WP   (C_WP),
  .C_RD   (C_RD),
  .C_REL  (C_REL)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_ce_n  (mem_ce_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_addr  (mem_addr),
  .drive_en  (dq_drive),
  .host_done (host_done)
);

// File: tb/sram_bus_ctrl_test.sv
module sram_bus_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        host_req;
  logic        host_wr;
  logic [20:0] host_addr;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        host_done;
  logic [20:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n;
  wire  [7:0]  mem_dq;

  int n_cmp = 0;
  int n_bad = 0;
  int n_issued = 0;
  int n_done = 0;
  bit finished = 0;

  typedef struct packed { logic is_rd; logic [7:0] data; } sb_item_t;
  sb_item_t sb_q[$];

  logic [7:0] mem_m [64];
  logic [7:0] exp_m [64];

  sram_bus_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_req   (host_req),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .host_done  (host_done),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq     (mem_dq)
  );

  // Memory model: drives the bus only while chip select and output enable are low.
  assign mem_dq = (!mem_ce_n && !mem_oe_n) ? mem_m[mem_addr[5:0]] : 8'bz;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: timing measurements, memory write commit and scoreboard pops.
  int   we_run = 0, oe_run = 0, ce_hi = 0;
  bit   oe_in_we = 0, prev_ce = 1, seen_ce = 0, prev_done = 0, addr_moved = 0;
  bit   wr_pend = 0;
  logic [5:0]  wr_a;
  logic [7:0]  wr_d;
  logic [20:0] prev_addr;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_we_n) begin
        we_run++;
        if (!mem_oe_n) oe_in_we = 1;
      end else if (we_run > 0) begin
        check(we_run == 3, "R2 write strobe width", we_run, 3);
        check(!oe_in_we, "R3 output enable high during write", oe_in_we, 0);
        we_run = 0;
        oe_in_we = 0;
      end
      if (!mem_oe_n) oe_run++;
      else if (oe_run > 0) begin
        check(oe_run == 4, "R6 read access width", oe_run, 4);
        oe_run = 0;
      end
      if (!mem_ce_n && prev_ce) begin
        if (seen_ce) check(ce_hi >= 2, "R9 chip select recovery", ce_hi, 2);
        seen_ce = 1;
        ce_hi = 0;
        addr_moved = 0;
      end
      if (!mem_ce_n && !prev_ce && mem_addr != prev_addr) addr_moved = 1;
      if (mem_ce_n && !prev_ce) check(!addr_moved, "R4 address stable", addr_moved, 0);
      if (mem_ce_n) ce_hi++;
      if (!mem_we_n && !mem_ce_n) begin
        wr_pend = 1;
        wr_a = mem_addr[5:0];
        wr_d = mem_dq;
      end else if (wr_pend) begin
        mem_m[wr_a] = wr_d;
        wr_pend = 0;
      end
      if (host_done) begin
        n_done++;
        if (prev_done) check(0, "R8 done longer than one cycle", 1, 0);
        if (sb_q.size() == 0) check(0, "R8 done without request", 1, 0);
        else begin
          sb_item_t it;
          it = sb_q.pop_front();
          if (it.is_rd) check(host_rdata == it.data, "R6 read data", host_rdata, it.data);
        end
      end
      prev_done = host_done;
      prev_ce = mem_ce_n;
      prev_addr = mem_addr;
    end
  end

  // Driver: issue one request and wait for its completion.
  task automatic issue(input bit wr, input logic [20:0] a, input logic [7:0] d,
                       input bit scramble);
    sb_item_t it;
    it.is_rd = !wr;
    it.data  = wr ? d : exp_m[a[5:0]];
    if (wr) exp_m[a[5:0]] = d;
    sb_q.push_back(it);
    n_issued++;
    host_req   = 1'b1;
    host_wr    = wr;
    host_addr  = a;
    host_wdata = d;
    @(negedge clk);
    while (mem_ce_n) @(negedge clk);
    if (scramble) begin
      host_addr  = ~a;
      host_wdata = ~d;
      host_wr    = !wr;
    end
    while (!host_done) @(negedge clk);
    host_req = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      report();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem_m[i] = 8'(i) ^ 8'h5A;
      exp_m[i] = 8'(i) ^ 8'h5A;
    end
    rst_n = 1'b0;
    host_req = 1'b0;
    host_wr = 1'b0;
    host_addr = '0;
    host_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: idle strobes during reset
    check(mem_ce_n === 1'b1, "R1 ce_n in reset", mem_ce_n, 1);
    check(mem_we_n === 1'b1, "R1 we_n in reset", mem_we_n, 1);
    check(mem_oe_n === 1'b1, "R1 oe_n in reset", mem_oe_n, 1);
    check(host_done === 1'b0, "R1 done in reset", host_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_ce_n === 1'b1 && mem_oe_n === 1'b1, "R1 idle after reset",
          {mem_ce_n, mem_oe_n}, 2'b11);

    // R2 R3 R5: writes with distinct data patterns and wide address spread
    issue(1, 21'h000003, 8'h3C, 0);
    issue(1, 21'h1FFFC5, 8'hFF, 0);
    issue(1, 21'h0ABC0A, 8'h00, 0);
    // R5 R6: read back written bytes and one untouched location
    issue(0, 21'h000003, 8'h00, 0);
    issue(0, 21'h1FFFC5, 8'h00, 0);
    issue(0, 21'h0ABC0A, 8'h00, 0);
    issue(0, 21'h00001F, 8'h00, 0);
    // R7: write directly after a read, then read it back
    issue(0, 21'h10002A, 8'h00, 0);
    issue(1, 21'h10002A, 8'h96, 0);
    issue(0, 21'h10002A, 8'h00, 0);
    // R10: host inputs scrambled after acceptance have no effect
    issue(1, 21'h000011, 8'hA5, 1);
    issue(0, 21'h000011, 8'h00, 0);
    issue(0, 21'h1FFFEE, 8'h00, 1);
    issue(0, 21'h000011, 8'h00, 0);
    // R9: alternating traffic
    for (int k = 0; k < 6; k++) begin
      issue(1, 21'(k * 21'h08421 + 32), 8'(k * 37 + 1), 0);
      issue(0, 21'(k * 21'h08421 + 32), 8'h00, 0);
    end

    repeat (10) @(negedge clk);
    // R8: one completion per request
    check(n_done == n_issued, "R8 completion count", n_done, n_issued);
    check(sb_q.size() == 0, "R8 scoreboard drained", sb_q.size(), 0);
    check(mem_ce_n === 1'b1 && host_done === 1'b0, "R10 no acceptance without request",
          {mem_ce_n, host_done}, 2'b10);
    finished = 1;
    report();
    $finish;
  end

endmodule